// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This block runs loop control beside the instruction pipeline, so a loop body pays no instruction slots for its branch-back. An enter command, carried by an issued instruction, loads a new loop context: the start address (the address after the enter instruction), an iteration count and an optional flag condition. Before the load, the context that was live is pushed onto a small internal stack. Any issued instruction may carry an end-of-loop marker. When it does, the controller decrements the count. In the same cycle it either raises a fetch redirect to the loop start or lets execution fall through. Falling through pops the enclosing context.

An early-exit branch also pops the saved context. This lets nested loops unwind cleanly. The condition reads a flag vector. The flag producer of the immediately preceding instruction is forwarded into the test when it writes in the same cycle. Stack misuse is recorded in a sticky error bit.

Top module: `zloop_ctrl`

## Requirements
- R1: An issued enter command (`issue_valid` and `enter_valid`) loads `issue_pc + 1` as the loop start, together with `enter_count` and `enter_cond`. From the next cycle `loop_active` is 1 and `loop_count` equals `enter_count`.
- R2: An issued end-of-loop instruction in an active loop replaces the count with count minus one. A count of zero stays zero. The new value is seen on `loop_count` in the following cycle when the loop repeats.
- R3: `redirect_valid` rises combinationally in the same cycle as the end-of-loop issue, with `redirect_pc` equal to the loop start. It does so exactly when the decremented count is non-zero or the selected condition is not met.
- R4: With the condition disabled, only the count decides. A loop entered with count N (N at least 1) redirects N-1 times and then falls through. A count of 0 gives one pass.
- R5: `enter_cond` bit 3 enables the condition, bit 2 inverts it, and bits 1:0 select a flag. The condition is met when the selected flag XOR the invert bit is 1.
- R6: The flag value tested is `flag_wr_data` when `flag_wr_valid` is high in that cycle. Otherwise it is the most recently written flag value, which is zero after reset.
- R7: Enter saves the live context (active bit, start, count, condition) and `loop_depth` rises by one. Falling through restores the saved context and `loop_depth` falls by one.
- R8: An issued `exit_valid` restores the saved context without a redirect, and `loop_depth` falls by one.
- R9: On one issue, enter beats exit and exit beats end-of-loop. End-of-loop with no active loop has no effect. Nothing changes and no redirect occurs while `issue_valid` is low.
- R10: The stack holds 4 contexts. An enter at depth 4 discards the save but still loads the new loop. A pop at depth 0 yields an idle context. Either case sets `stack_err`, which stays set until reset.
- R11: After reset `loop_active`, `loop_count`, `loop_depth`, `stack_err` and `redirect_valid` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | An instruction issues this cycle |
| issue_pc | input | 16 | Address of the issuing instruction |
| issue_eol | input | 1 | End-of-loop marker of the issuing instruction |
| enter_valid | input | 1 | Issuing instruction is an enter-loop command |
| enter_count | input | 16 | Iteration count for the new loop |
| enter_cond | input | 4 | Condition selector {enable, invert, flag index} |
| exit_valid | input | 1 | Issuing instruction is an early-exit branch |
| flag_wr_valid | input | 1 | Flags of the preceding instruction are written now |
| flag_wr_data | input | 4 | Flag values being written |
| redirect_valid | output | 1 | Redirect fetch to the loop start |
| redirect_pc | output | 16 | Loop start address |
| loop_active | output | 1 | A loop context is live |
| loop_count | output | 16 | Remaining count of the live loop |
| loop_depth | output | 3 | Saved contexts on the stack |
| stack_err | output | 1 | Sticky stack overflow/underflow flag |

## Verification
On every cycle the assertions check the following. A redirect appears only for an issued end-of-loop instruction inside a live loop. A repeat leaves the count one lower. Enter and exit move the depth by one. The depth never passes the stack size. The error bit never clears. Only the bench scenarios can show that the right start address and outer count come back after nesting and early exit, that the flag bypass wins over the stored flags, how the inverted and plain conditions behave, and the exact overflow and underflow sequences, because these need an independent model of the saved contexts.

// File: rtl/zloop_pkg.sv
package zloop_pkg;
  // Action chosen for one issue slot.
  typedef enum logic [2:0] {
    ACT_NONE   = 3'd0,
    ACT_ENTER  = 3'd1,
    ACT_EXIT   = 3'd2,
    ACT_REPEAT = 3'd3,
    ACT_LEAVE  = 3'd4
  } loop_act_e;

  // Bit positions inside the condition selector (above the flag index).
  localparam int unsigned COND_EN_OFS  = 1;
  localparam int unsigned COND_INV_OFS = 0;
endpackage

// File: rtl/zloop_rst_sync.sv
module zloop_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/zloop_cond.sv
module zloop_cond #(
  parameter int unsigned FLAG_N = 4,
  localparam int unsigned IDX_W  = $clog2(FLAG_N),
  localparam int unsigned COND_W = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flag_wr_valid,
  input  logic [FLAG_N-1:0] flag_wr_data,
  input  logic [COND_W-1:0] cond_code,
  output logic              cond_met
);
  import zloop_pkg::*;

  logic [FLAG_N-1:0] flag_q, flag_d, flag_eff;
  logic              flag_en;
  logic              sel_flag;
  logic              c_en, c_inv;
  logic [IDX_W-1:0]  c_idx;

  // Next state of the stored flag copy
  always_comb begin
    flag_en = flag_wr_valid;
    flag_d  = flag_wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= '0;
    else if (flag_en) flag_q <= flag_d;
  end

  // Bypass: a same-cycle write wins over the stored copy
  always_comb begin
    flag_eff = flag_wr_valid ? flag_wr_data : flag_q;
    c_en     = cond_code[IDX_W + COND_EN_OFS];
    c_inv    = cond_code[IDX_W + COND_INV_OFS];
    c_idx    = cond_code[IDX_W-1:0];
    sel_flag = flag_eff[c_idx];
    cond_met = !c_en || (sel_flag ^ c_inv);
  end
endmodule

// File: rtl/zloop_stack.sv
module zloop_stack #(
  parameter int unsigned ENTRY_W = 37,
  parameter int unsigned DEPTH   = 4,
  localparam int unsigned PTR_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic               pop,
  input  logic [ENTRY_W-1:0] push_data,
  output logic [ENTRY_W-1:0] pop_data,
  output logic [PTR_W-1:0]   depth,
  output logic               err
);
  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]   ptr_q, ptr_d;
  logic               ptr_en;
  logic               full, empty;
  logic               err_q, err_d, err_en;

  assign full  = (ptr_q == PTR_W'(DEPTH));
  assign empty = (ptr_q == '0);

  // Pointer and error next state
  always_comb begin
    ptr_d  = ptr_q;
    ptr_en = 1'b0;
    err_d  = 1'b1;
    err_en = 1'b0;
    if (push) begin
      if (full) err_en = 1'b1;
      else begin
        ptr_d  = ptr_q + PTR_W'(1);
        ptr_en = 1'b1;
      end
    end else if (pop) begin
      if (empty) err_en = 1'b1;
      else begin
        ptr_d  = ptr_q - PTR_W'(1);
        ptr_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (err_en) err_q <= err_d;
  end

  // One write-enabled register per entry
  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic wr_en;
    assign wr_en = push && !full && (ptr_q == PTR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mem[g] <= '0;
      else if (wr_en) mem[g] <= push_data;
    end
  end

  // Top-of-stack read; an empty stack yields an idle context
  always_comb begin
    pop_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ptr_q == PTR_W'(i + 1)) pop_data = mem[i];
    end
  end

  assign depth = ptr_q;
  assign err   = err_q;
endmodule

// File: rtl/zloop_decide.sv
module zloop_decide #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             issue_valid,
  input  logic             enter_valid,
  input  logic             exit_valid,
  input  logic             issue_eol,
  input  logic             active,
  input  logic [CNT_W-1:0] count,
  input  logic             cond_met,
  output zloop_pkg::loop_act_e act,
  output logic [CNT_W-1:0] count_dec,
  output logic             redirect
);
  import zloop_pkg::*;

  logic again;

  always_comb begin
    count_dec = (count == '0) ? '0 : (count - CNT_W'(1));
    again     = (count_dec != '0) || !cond_met;
    act       = ACT_NONE;
    if (issue_valid) begin
      if (enter_valid)              act = ACT_ENTER;
      else if (exit_valid)          act = ACT_EXIT;
      else if (issue_eol && active) act = again ? ACT_REPEAT : ACT_LEAVE;
    end
    redirect = (act == ACT_REPEAT);
  end
endmodule

// File: rtl/zloop_ctrl.sv
module zloop_ctrl #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned FLAG_N = 4,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned IDX_W  = $clog2(FLAG_N),
  localparam int unsigned COND_W = IDX_W + 2,
  localparam int unsigned DEP_W  = $clog2(DEPTH + 1),
  localparam int unsigned CTX_W  = 1 + ADDR_W + CNT_W + COND_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  input  logic [ADDR_W-1:0] issue_pc,
  input  logic              issue_eol,
  input  logic              enter_valid,
  input  logic [CNT_W-1:0]  enter_count,
  input  logic [COND_W-1:0] enter_cond,
  input  logic              exit_valid,
  input  logic              flag_wr_valid,
  input  logic [FLAG_N-1:0] flag_wr_data,
  output logic              redirect_valid,
  output logic [ADDR_W-1:0] redirect_pc,
  output logic              loop_active,
  output logic [CNT_W-1:0]  loop_count,
  output logic [DEP_W-1:0]  loop_depth,
  output logic              stack_err
);
  import zloop_pkg::*;

  logic core_rst_n;

  // Live loop context
  logic              act_q, act_d;
  logic [ADDR_W-1:0] start_q, start_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [COND_W-1:0] cond_q, cond_d;
  logic              ctx_en;

  logic              cond_met;
  loop_act_e         act;
  logic [CNT_W-1:0]  count_dec;
  logic              redirect;
  logic              push, pop;
  logic [CTX_W-1:0]  push_data, pop_data;

  zloop_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (core_rst_n)
  );

  zloop_cond #(.FLAG_N(FLAG_N)) u_cond (
    .clk           (clk),
    .rst_n         (core_rst_n),
    .flag_wr_valid (flag_wr_valid),
    .flag_wr_data  (flag_wr_data),
    .cond_code     (cond_q),
    .cond_met      (cond_met)
  );

  zloop_decide #(.CNT_W(CNT_W)) u_decide (
    .issue_valid (issue_valid),
    .enter_valid (enter_valid),
    .exit_valid  (exit_valid),
    .issue_eol   (issue_eol),
    .active      (act_q),
    .count       (cnt_q),
    .cond_met    (cond_met),
    .act         (act),
    .count_dec   (count_dec),
    .redirect    (redirect)
  );

  zloop_stack #(.ENTRY_W(CTX_W), .DEPTH(DEPTH)) u_stack (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .push      (push),
    .pop       (pop),
    .push_data (push_data),
    .pop_data  (pop_data),
    .depth     (loop_depth),
    .err       (stack_err)
  );

  assign push_data = {act_q, start_q, cnt_q, cond_q};

  // Next-state of the live context
  always_comb begin
    act_d   = act_q;
    start_d = start_q;
    cnt_d   = cnt_q;
    cond_d  = cond_q;
    push    = 1'b0;
    pop     = 1'b0;
    ctx_en  = 1'b0;
    unique case (act)
      ACT_ENTER: begin
        push    = 1'b1;
        ctx_en  = 1'b1;
        act_d   = 1'b1;
        start_d = issue_pc + ADDR_W'(1);
        cnt_d   = enter_count;
        cond_d  = enter_cond;
      end
      ACT_EXIT, ACT_LEAVE: begin
        pop    = 1'b1;
        ctx_en = 1'b1;
        {act_d, start_d, cnt_d, cond_d} = pop_data;
      end
      ACT_REPEAT: begin
        ctx_en = 1'b1;
        cnt_d  = count_dec;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      act_q   <= 1'b0;
      start_q <= '0;
      cnt_q   <= '0;
      cond_q  <= '0;
    end else if (ctx_en) begin
      act_q   <= act_d;
      start_q <= start_d;
      cnt_q   <= cnt_d;
      cond_q  <= cond_d;
    end
  end

  assign redirect_valid = redirect;
  assign redirect_pc    = start_q;
  assign loop_active    = act_q;
  assign loop_count     = cnt_q;
endmodule

// File: rtl/zloop_ctrl_chk.sv
module zloop_ctrl_chk #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned DEP_W = 3
) (
  input logic             clk,
  input logic             core_rst_n,
  input logic             issue_valid,
  input logic             issue_eol,
  input logic             enter_valid,
  input logic [CNT_W-1:0] enter_count,
  input logic             exit_valid,
  input logic             redirect_valid,
  input logic             loop_active,
  input logic [CNT_W-1:0] loop_count,
  input logic [DEP_W-1:0] loop_depth,
  input logic             stack_err
);
  p_redirect_source_r3: assert property (@(posedge clk) disable iff (!core_rst_n)
    redirect_valid |-> (loop_active && issue_valid && issue_eol && !enter_valid && !exit_valid));

  p_enter_loads_r1: assert property (@(posedge clk) disable iff (!core_rst_n)
    (issue_valid && enter_valid) |=> (loop_active && loop_count == $past(enter_count)));

  p_repeat_decrements_r2: assert property (@(posedge clk) disable iff (!core_rst_n)
    redirect_valid |=> (loop_active &&
      loop_count == (($past(loop_count) == '0) ? '0 : ($past(loop_count) - CNT_W'(1)))));

  p_enter_push_r7: assert property (@(posedge clk) disable iff (!core_rst_n)
    (issue_valid && enter_valid && loop_depth < DEP_W'(DEPTH))
      |=> (loop_depth == $past(loop_depth) + DEP_W'(1)));

  p_exit_pop_r8: assert property (@(posedge clk) disable iff (!core_rst_n)
    (issue_valid && !enter_valid && exit_valid && loop_depth != '0)
      |=> (loop_depth == $past(loop_depth) - DEP_W'(1)));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!core_rst_n)
    !issue_valid |-> !redirect_valid);

  p_depth_bound_r10: assert property (@(posedge clk) disable iff (!core_rst_n)
    loop_depth <= DEP_W'(DEPTH));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!core_rst_n)
    stack_err |=> stack_err);
endmodule

bind zloop_ctrl zloop_ctrl_chk #(.CNT_W(CNT_W), .DEPTH(DEPTH), .DEP_W(DEP_W)) u_chk (
  .clk            (clk),
  .core_rst_n     (core_rst_n),
  .issue_valid    (issue_valid),
  .issue_eol      (issue_eol),
  .enter_valid    (enter_valid),
  .enter_count    (enter_count),
  .exit_valid     (exit_valid),
  .redirect_valid (redirect_valid),
  .loop_active    (loop_active),
  .loop_count     (loop_count),
  .loop_depth     (loop_depth),
  .stack_err      (stack_err)
);

// File: tb/tb_zloop_ctrl.sv
module tb_zloop_ctrl;
  logic        clk;
  logic        rst_n;
  logic        issue_valid, issue_eol, enter_valid, exit_valid, flag_wr_valid;
  logic [15:0] issue_pc, enter_count;
  logic [3:0]  enter_cond, flag_wr_data;
  logic        redirect_valid, loop_active, stack_err;
  logic [15:0] redirect_pc, loop_count;
  logic [2:0]  loop_depth;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  zloop_ctrl dut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_pc(issue_pc),
    .issue_eol(issue_eol), .enter_valid(enter_valid), .enter_count(enter_count),
    .enter_cond(enter_cond), .exit_valid(exit_valid), .flag_wr_valid(flag_wr_valid),
    .flag_wr_data(flag_wr_data), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .loop_active(loop_active), .loop_count(loop_count), .loop_depth(loop_depth),
    .stack_err(stack_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    bit          rv;
    logic [15:0] rpc;
    bit          act;
    logic [15:0] cnt;
    int          dep;
    bit          err;
    string       tag;
  } exp_t;
  exp_t q[$];

  // Reference model of the requirements
  bit          m_act;
  logic [15:0] m_start, m_cnt;
  logic [3:0]  m_cond, m_flag;
  bit          s_act [4];
  logic [15:0] s_start [4];
  logic [15:0] s_cnt [4];
  logic [3:0]  s_cond [4];
  int          m_dep;
  bit          m_err;

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] want);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, want);
    end
  endtask

  task automatic m_pop();
    if (m_dep > 0) begin
      m_dep--;
      m_act = s_act[m_dep]; m_start = s_start[m_dep];
      m_cnt = s_cnt[m_dep]; m_cond = s_cond[m_dep];
    end else begin
      m_err = 1; m_act = 0; m_start = 0; m_cnt = 0; m_cond = 0;
    end
  endtask

  task automatic step(bit iv, bit en, bit ex, bit eol, logic [15:0] pc, logic [15:0] cnt,
                      logic [3:0] cond, bit fwv, logic [3:0] fwd, string tag);
    exp_t e;
    logic [3:0]  eff;
    logic [15:0] nxt;
    bit met, rep;
    @(negedge clk);
    issue_valid = iv; enter_valid = en; exit_valid = ex; issue_eol = eol;
    issue_pc = pc; enter_count = cnt; enter_cond = cond;
    flag_wr_valid = fwv; flag_wr_data = fwd;
    eff = fwv ? fwd : m_flag;
    nxt = (m_cnt == 0) ? 16'd0 : m_cnt - 16'd1;
    met = !m_cond[3] || (eff[m_cond[1:0]] ^ m_cond[2]);
    rep = (nxt != 0) || !met;
    e.rv  = iv && !en && !ex && eol && m_act && rep;
    e.rpc = m_start;
    if (fwv) m_flag = fwd;
    if (iv) begin
      if (en) begin
        if (m_dep < 4) begin
          s_act[m_dep] = m_act; s_start[m_dep] = m_start;
          s_cnt[m_dep] = m_cnt; s_cond[m_dep] = m_cond;
          m_dep++;
        end else m_err = 1;
        m_act = 1; m_start = pc + 16'd1; m_cnt = cnt; m_cond = cond;
      end else if (ex) m_pop();
      else if (eol && m_act) begin
        if (rep) m_cnt = nxt;
        else m_pop();
      end
    end
    e.act = m_act; e.cnt = m_cnt; e.dep = m_dep; e.err = m_err; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic nop(logic [15:0] pc, string tag);
    step(1, 0, 0, 0, pc, 0, 0, 0, 0, tag);
  endtask
  task automatic eol_i(logic [15:0] pc, string tag);
    step(1, 0, 0, 1, pc, 0, 0, 0, 0, tag);
  endtask
  task automatic enter(logic [15:0] pc, logic [15:0] cnt, logic [3:0] cond, string tag);
    step(1, 1, 0, 0, pc, cnt, cond, 0, 0, tag);
  endtask
  task automatic leave_br(logic [15:0] pc, string tag);
    step(1, 0, 1, 0, pc, 0, 0, 0, 0, tag);
  endtask

  // Scoreboard monitor
  initial begin
    exp_t it;
    forever begin
      @(negedge clk); #5;
      if (q.size() > 0) begin
        it = q.pop_front();
        chk(it.tag, "redirect_valid", 32'(redirect_valid), 32'(it.rv));
        if (it.rv) chk(it.tag, "redirect_pc", 32'(redirect_pc), 32'(it.rpc));
        @(posedge clk); #5;
        chk(it.tag, "loop_active", 32'(loop_active), 32'(it.act));
        chk(it.tag, "loop_count", 32'(loop_count), 32'(it.cnt));
        chk(it.tag, "loop_depth", 32'(loop_depth), 32'(it.dep));
        chk(it.tag, "stack_err", 32'(stack_err), 32'(it.err));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    m_act = 0; m_start = 0; m_cnt = 0; m_cond = 0; m_flag = 0; m_dep = 0; m_err = 0;
    rst_n = 1'b0;
    issue_valid = 0; enter_valid = 0; exit_valid = 0; issue_eol = 0;
    issue_pc = 0; enter_count = 0; enter_cond = 0; flag_wr_valid = 0; flag_wr_data = 0;
    repeat (3) @(negedge clk);
    // R11: state held at reset
    chk("R11", "loop_active", 32'(loop_active), 0);
    chk("R11", "loop_depth", 32'(loop_depth), 0);
    chk("R11", "stack_err", 32'(stack_err), 0);
    chk("R11", "redirect_valid", 32'(redirect_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R11");

    // R1 R2 R3 R4 R7: plain count of 3
    enter(16'h0010, 3, 4'b0000, "R1");
    nop(16'h0011, "R1");
    eol_i(16'h0012, "R3");
    nop(16'h0011, "R2");
    eol_i(16'h0012, "R2");
    nop(16'h0011, "R4");
    eol_i(16'h0012, "R4");
    // R4: count 0 gives one pass
    enter(16'h0020, 0, 4'b0000, "R4");
    eol_i(16'h0021, "R4");

    // R5 R6: condition on flag 2, bypass beats stored flag
    step(0, 0, 0, 0, 0, 0, 0, 1, 4'b0100, "R6");
    enter(16'h0030, 1, 4'b1010, "R5");
    step(1, 0, 0, 1, 16'h0031, 0, 0, 1, 4'b0000, "R6");
    eol_i(16'h0031, "R6");
    step(1, 0, 0, 1, 16'h0031, 0, 0, 1, 4'b0100, "R5");
    // R5: inverted flag 0
    enter(16'h0038, 1, 4'b1100, "R5");
    step(1, 0, 0, 1, 16'h0039, 0, 0, 1, 4'b0001, "R5");
    step(1, 0, 0, 1, 16'h0039, 0, 0, 1, 4'b0000, "R5");

    // R7 R8: nesting with early exit
    enter(16'h0040, 2, 4'b0000, "R7");
    enter(16'h0042, 5, 4'b0000, "R7");
    eol_i(16'h0043, "R7");
    leave_br(16'h0044, "R8");
    eol_i(16'h0045, "R8");
    eol_i(16'h0045, "R8");
    // R7: inner fall-through restores outer
    enter(16'h0050, 2, 4'b0000, "R7");
    enter(16'h0052, 1, 4'b0000, "R7");
    eol_i(16'h0053, "R7");
    eol_i(16'h0054, "R7");
    eol_i(16'h0054, "R7");

    // R9: priorities and ignored inputs
    eol_i(16'h0060, "R9");
    step(0, 1, 0, 1, 16'h0061, 7, 0, 0, 0, "R9");
    step(1, 1, 0, 1, 16'h0062, 4, 4'b0000, 0, 0, "R9");
    step(0, 0, 1, 1, 16'h0063, 0, 0, 0, 0, "R9");
    step(1, 0, 1, 1, 16'h0063, 0, 0, 0, 0, "R9");

    // R10: overflow then underflow, sticky error
    for (int i = 0; i < 5; i++) enter(16'h0070 + 16'(i), 16'(i + 2), 4'b0000, "R10");
    eol_i(16'h0076, "R10");
    for (int i = 0; i < 5; i++) leave_br(16'h0080, "R10");
    nop(16'h0090, "R10");

    wait (q.size() == 0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule